// File: doc/BRIEF.md
# Debounced 4x4 Matrix Keypad Scanner

This block reads a sixteen-key matrix keypad. It drives one column line high at a time and reads the four row lines, which idle low. When the driven column shows a closed contact, the block stops scanning. It waits until the same key has read the same for a set number of slow ticks, then reports one hex keycode with a one-cycle valid strobe. The strobe is what separates key 0 from "no key".

After a report, the column stays put until every row has read low for the same number of ticks. A contact that chatters therefore gives exactly one report per press. All slow timing comes from an enable tick made on the system clock, so the block adds no extra clock domain. The tick period, the dwell time per column and the debounce hold time are parameters that are set to match a given keypad.

Top module: `kp_matrix_scan`

## Requirements
- R1: `col_o` is always one-hot, active high. With no key down, the driven column steps 0, 1, 2, 3, 0 … (bit 0 first, shifting left). Each column is held for exactly `DWELL_TICKS` ticks, which is `DWELL_TICKS*TICK_DIV` clock cycles.
- R2: Rows are active high. Row r (bit r of `row_i`) with column c gives these codes. For r and c both in 0..2 the code is 3r+c+1, which covers digits 1 to 9.
- R3: Column 3 gives 0xA, 0xB, 0xC, 0xD for rows 0 to 3. On row 3, column 0 (the star key) gives 0xE, column 1 gives 0x0 and column 2 (the hash key) gives 0xF.
- R4: `key_pressed_o` is high for exactly one clock cycle per accepted press. `key_code_o` is valid in that cycle and holds its value until the next report.
- R5: A key is reported only after it has read the same on `HOLD_TICKS` consecutive ticks, counting the tick that first saw it. A contact that never stays closed for that long produces no report.
- R6: After a report, `col_o` stays on the reporting column until all rows read 0 on `HOLD_TICKS` consecutive ticks. An opening shorter than that, followed by a new closing, produces no second report.
- R7: When several rows are high on the driven column, the lowest-numbered row is the one reported.
- R8: After reset, column 0 is driven, `key_pressed_o` is 0 and `key_code_o` is 0x0. Ticks come from an enable that fires once every `TICK_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_i | input | 4 | Row lines, high while a key on the driven column is closed |
| col_o | output | 4 | One-hot column drive, active high |
| key_code_o | output | 4 | Hex code of the last accepted key |
| key_pressed_o | output | 1 | One-cycle strobe when a debounced press is accepted |

## Verification
The bench walks all sixteen keys and checks each code against a formula worked out from the layout. A swapped row and column, or a wrong encoding for the star, hash or zero key, shows up as a wrong code. The bench also feeds a contact that chatters faster than the hold time. A design that debounces too short, or restarts its hold count wrongly, reports ghost keys there. It also checks a release glitch: a design that unfreezes the column too early reports the same key twice. Two rows closed at once test the priority rule, and a design that picks the top row reports the wrong key. The step timing of the idle column is measured in cycles to catch off-by-one dwell counters.

// File: rtl/kp_pkg.sv
package kp_pkg;

    typedef enum logic [1:0] {
        KP_SCAN    = 2'd0,
        KP_CONFIRM = 2'd1,
        KP_RELEASE = 2'd2
    } kp_state_e;

    typedef logic [3:0] kp_code_t;

    // Map (row, column) to the hex code printed on the keycap.
    function automatic kp_code_t kp_code_of(input logic [1:0] r, input logic [1:0] c);
        kp_code_t v;
        case ({r, c})
            4'b00_00: v = 4'h1;
            4'b00_01: v = 4'h2;
            4'b00_10: v = 4'h3;
            4'b00_11: v = 4'hA;
            4'b01_00: v = 4'h4;
            4'b01_01: v = 4'h5;
            4'b01_10: v = 4'h6;
            4'b01_11: v = 4'hB;
            4'b10_00: v = 4'h7;
            4'b10_01: v = 4'h8;
            4'b10_10: v = 4'h9;
            4'b10_11: v = 4'hC;
            4'b11_00: v = 4'hE;
            4'b11_01: v = 4'h0;
            4'b11_10: v = 4'hF;
            default:  v = 4'hD;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/kp_tick_gen.sv
module kp_tick_gen #(
    parameter int TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == LAST);

            assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/kp_key_encode.sv
module kp_key_encode
    import kp_pkg::*;
(
    input  logic [3:0] row_i,
    input  logic [1:0] col_idx_i,
    output logic       hit_o,
    output kp_code_t   code_o
);
    logic [1:0] row_sel;

    // Lowest-numbered active row has priority (R7).
    always_comb begin
        row_sel = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (row_i[i]) row_sel = 2'(i);
        end
    end

    assign hit_o  = |row_i;
    assign code_o = kp_code_of(row_sel, col_idx_i);
endmodule

// File: rtl/kp_scan_fsm.sv
module kp_scan_fsm
    import kp_pkg::*;
#(
    parameter int DWELL_TICKS = 4,
    parameter int HOLD_TICKS  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       hit_i,
    input  kp_code_t   code_i,
    output logic [1:0] col_idx_o,
    output logic [3:0] col_o,
    output kp_code_t   key_code_o,
    output logic       key_pressed_o
);
    localparam int MAXT = (DWELL_TICKS > HOLD_TICKS) ? DWELL_TICKS : HOLD_TICKS;
    localparam int TW   = (MAXT > 1) ? $clog2(MAXT) : 1;
    localparam logic [TW-1:0] DWELL_LAST = TW'(DWELL_TICKS - 1);
    localparam logic [TW-1:0] HOLD_LAST  = TW'(HOLD_TICKS - 1);

    typedef struct packed {
        kp_state_e     st;
        logic [1:0]    col;
        logic [TW-1:0] tmr;
        kp_code_t      cand;
        kp_code_t      code;
        logic          strobe;
    } scan_t;

    scan_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        if (tick_i) begin
            case (s_q.st)
                KP_SCAN: begin
                    if (hit_i) begin
                        s_d.st   = KP_CONFIRM;
                        s_d.cand = code_i;
                        s_d.tmr  = '0;
                        if (HOLD_TICKS <= 1) begin
                            s_d.st     = KP_RELEASE;
                            s_d.code   = code_i;
                            s_d.strobe = 1'b1;
                        end
                    end else if (s_q.tmr == DWELL_LAST) begin
                        s_d.col = s_q.col + 2'd1;
                        s_d.tmr = '0;
                    end else begin
                        s_d.tmr = s_q.tmr + 1'b1;
                    end
                end
                KP_CONFIRM: begin
                    if (!hit_i || code_i != s_q.cand) begin
                        s_d.st  = KP_SCAN;
                        s_d.tmr = '0;
                    end else if (s_q.tmr + 1'b1 == HOLD_LAST) begin
                        s_d.st     = KP_RELEASE;
                        s_d.code   = s_q.cand;
                        s_d.strobe = 1'b1;
                        s_d.tmr    = '0;
                    end else begin
                        s_d.tmr = s_q.tmr + 1'b1;
                    end
                end
                KP_RELEASE: begin
                    if (hit_i) begin
                        s_d.tmr = '0;
                    end else if (s_q.tmr == HOLD_LAST) begin
                        s_d.st  = KP_SCAN;
                        s_d.tmr = '0;
                    end else begin
                        s_d.tmr = s_q.tmr + 1'b1;
                    end
                end
                default: begin
                    s_d.st  = KP_SCAN;
                    s_d.tmr = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: KP_SCAN, col: 2'd0, tmr: '0, cand: 4'h0, code: 4'h0, strobe: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign col_idx_o     = s_q.col;
    assign col_o         = 4'b0001 << s_q.col;
    assign key_code_o    = s_q.code;
    assign key_pressed_o = s_q.strobe;

    assert_col_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(col_o));

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        key_pressed_o |=> !key_pressed_o);

    assert_strobe_after_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        key_pressed_o |-> (s_q.st == KP_RELEASE && $past(s_q.st) != KP_RELEASE));

    assert_col_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != KP_SCAN) |=> $stable(col_o));
endmodule

// File: rtl/kp_matrix_scan.sv
module kp_matrix_scan
    import kp_pkg::*;
#(
    parameter int TICK_DIV    = 50000,
    parameter int DWELL_TICKS = 4,
    parameter int HOLD_TICKS  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] row_i,
    output logic [3:0] col_o,
    output logic [3:0] key_code_o,
    output logic       key_pressed_o
);
    logic       tick;
    logic       hit;
    kp_code_t   code;
    logic [1:0] col_idx;

    kp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    kp_key_encode u_enc (
        .row_i     (row_i),
        .col_idx_i (col_idx),
        .hit_o     (hit),
        .code_o    (code)
    );

    kp_scan_fsm #(.DWELL_TICKS(DWELL_TICKS), .HOLD_TICKS(HOLD_TICKS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .hit_i         (hit),
        .code_i        (code),
        .col_idx_o     (col_idx),
        .col_o         (col_o),
        .key_code_o    (key_code_o),
        .key_pressed_o (key_pressed_o)
    );
endmodule

// File: tb/kp_matrix_scan_bench.sv
module kp_matrix_scan_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV  = 2;
    localparam int DWELL = 2;
    localparam int HOLD  = 3;
    localparam int WATCHDOG_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] row_i;
    logic [3:0] col_o;
    logic [3:0] key_code_o;
    logic       key_pressed_o;
    logic [15:0] keys = '0;   // bit r*4+c closes row r / column c

    int checks = 0;
    int fails  = 0;
    int strobes = 0;
    int cyc = 0;
    logic [3:0] last_code = 4'h0;
    logic prev_strobe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        for (int r = 0; r < 4; r++) row_i[r] = |(keys[r*4 +: 4] & col_o);
    end

    kp_matrix_scan #(.TICK_DIV(TDIV), .DWELL_TICKS(DWELL), .HOLD_TICKS(HOLD)) u_kp_matrix_scan (
        .clk(clk), .rst_n(rst_n), .row_i(row_i), .col_o(col_o),
        .key_code_o(key_code_o), .key_pressed_o(key_pressed_o)
    );

    // Strobe monitor: R4 one-cycle width.
    always @(negedge clk) begin
        if (rst_n && key_pressed_o) begin
            strobes++;
            last_code = key_code_o;
            checks++;
            if (prev_strobe) begin
                fails++;
                $display("FAIL R4 strobe width: actual >1 cycle expected 1");
            end
        end
        prev_strobe = key_pressed_o;
    end

    function automatic logic [3:0] expect_code(int r, int c);
        if (c == 3)      return 4'(10 + r);
        else if (r == 3) return (c == 0) ? 4'hE : ((c == 1) ? 4'h0 : 4'hF);
        else             return 4'(r * 3 + c + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press_key(input int r, input int c, input string req);
        int base, t0, lat;
        base = strobes;
        t0 = cyc;
        keys = 16'(1) << (r*4 + c);
        while (strobes == base && cyc - t0 < 200) @(negedge clk);
        lat = cyc - t0;
        check(strobes == base + 1, req, strobes - base, 1);
        check(last_code == expect_code(r, c), req, last_code, expect_code(r, c));
        // R5 lower bound: HOLD ticks of agreement; R5 upper bound from scan length
        check(lat >= (HOLD-1)*TDIV && lat <= (4*DWELL + HOLD + 2)*TDIV + 4, "R5 latency",
              lat, HOLD*TDIV);
        idle(40);
        check(strobes == base + 1, "R4 single strobe while held", strobes - base, 1);
        check(col_o == 4'(1 << c), "R6 column frozen", col_o, 1 << c);
        keys = '0;
        idle(40);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int base;
        logic [3:0] pc;
        int tprev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(col_o == 4'b0001, "R8 reset column", col_o, 1);
        check(key_pressed_o == 1'b0, "R8 reset strobe", key_pressed_o, 0);
        check(key_code_o == 4'h0, "R8 reset code", key_code_o, 0);

        // R1: idle dwell and order
        pc = col_o;
        while (col_o == pc) @(negedge clk);
        tprev = cyc;
        for (int k = 0; k < 8; k++) begin
            pc = col_o;
            while (col_o == pc) @(negedge clk);
            check(cyc - tprev == DWELL*TDIV, "R1 dwell", cyc - tprev, DWELL*TDIV);
            check(col_o == {pc[2:0], pc[3]}, "R1 order", col_o, {pc[2:0], pc[3]});
            tprev = cyc;
        end

        // R2 / R3: all sixteen keys
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                press_key(r, c, (c == 3 || r == 3) ? "R3 code" : "R2 code");

        // R7: two rows on one column
        base = strobes;
        keys = (16'(1) << (1*4 + 1)) | (16'(1) << (2*4 + 1));
        idle(60);
        check(strobes == base + 1, "R7 count", strobes - base, 1);
        check(last_code == expect_code(1, 1), "R7 lowest row", last_code, expect_code(1, 1));
        keys = '0; idle(40);
        base = strobes;
        keys = (16'(1) << (0*4 + 3)) | (16'(1) << (3*4 + 3));
        idle(60);
        check(last_code == 4'hA && strobes == base + 1, "R7 lowest row col3", last_code, 10);
        keys = '0; idle(40);

        // R5: chatter two ticks closed, two open never reports
        base = strobes;
        for (int k = 0; k < 20; k++) begin
            keys = 16'h0001; idle(2*TDIV);
            keys = '0;       idle(2*TDIV);
        end
        idle(40);
        check(strobes == base, "R5 chatter rejected", strobes - base, 0);

        // R6: short release glitch gives no second report
        base = strobes;
        keys = 16'(1) << (2*4 + 2);
        idle(60);
        check(strobes == base + 1 && last_code == 4'h9, "R6 first report", strobes - base, 1);
        keys = '0;  idle(2*TDIV);
        keys = 16'(1) << (2*4 + 2); idle(60);
        check(strobes == base + 1, "R6 glitch no repeat", strobes - base, 1);
        keys = '0; idle(40);
        keys = 16'(1) << (2*4 + 2); idle(60);
        check(strobes == base + 2, "R6 clean re-press reports", strobes - base, 2);
        keys = '0; idle(40);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule